// File: doc/BRIEF.md
# Dual-Master Bus Ownership Arbiter

This block decides which of two upstream bus masters is connected to a single shared downstream bus. Each master posts an ownership request through its own control write: a bit that claims the bus for itself, a bit that hands it to the other master, and a bit that asks for a recovery sequence on the downstream bus before the handover. A posted request stays pending until the master that wrote it signals a STOP on its own upstream bus. Only then does ownership move.

When ownership moves away from a master, that master is told through a lost-bus status flag. If recovery was asked for, the downstream bus stays isolated while an external sequencer runs. A level handshake starts that sequencer and a completion pulse ends it. The new owner is then connected and gets an init-done flag. Without recovery, the new owner is connected at once. It gets a bus-not-idle flag if the downstream bus was busy at that moment.

Each master has three status flags and three mask bits, and an active-low interrupt line. Reading a master's status clears it.

The FSM has two states, `ARB_HOLD` and `ARB_RECOVER`:
- In `ARB_HOLD` the owner, if there is one, is connected and ready requests are served.
- Serving a request that asks for recovery moves the FSM to `ARB_RECOVER`.
- In `ARB_RECOVER` all connections are off and `rec_start` is high. A `rec_done` pulse moves the FSM back to `ARB_HOLD`.

Top module: `dmbus_arbiter`

## Requirements
- R1: After reset no master is connected, `rec_start` is 0, every status and mask bit is 0, and both `int_n` lines are 1.
- R2: A control write from master m is decoded as follows:
  - self=1, peer=0 targets m.
  - self=0, peer=1 targets the other master.
  - self=0, peer=0 targets no owner (the bus is disconnected).
  - self=1, peer=1 is ignored and leaves any earlier pending request intact.
- R3: A pending request takes effect at the first clock edge where `up_stop` of its writer is high, or at a later edge if the FSM is busy. A STOP from the other master has no effect on it. A STOP that comes before the write has no effect on it.
- R4: A request whose target equals the current owner changes nothing and sets no flag.
- R5: When ownership moves away from a master, its lost-bus flag (bit 0 of its status field) is set in the same cycle its connection drops.
- R6: With recovery requested, the following happens in order:
  - All connections are off and `rec_start` stays high until `rec_done`.
  - The new owner is then connected.
  - Its init-done flag (bit 1) is set.

  This happens whether the bus was idle or not.
- R7: Without recovery, the new owner is connected at switch time. Its bus-not-idle flag (bit 2) is set only if `dn_idle` is 0 at that edge.
- R8: `int_n[m]` is 0 exactly when master m has a status bit set whose mask bit is 0. Master m's mask is loaded from `msk_val[3m+2:3m]` when `msk_we[m]` is high, using the same bit layout as the status.
- R9: `stat_rd[m]` clears master m's field `stat_o[3m+2:3m]` only. A flag set in the same cycle survives the clear.
- R10: If both masters' requests are ready in the same cycle, master 0 is served first and master 1 in the next `ARB_HOLD` cycle. Otherwise the one whose STOP came first is served first. A STOP that arrives during recovery is held until recovery ends.
- R11: At most one master is connected at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 2 | Control write strobe, one per master |
| ctl_self_on | input | 2 | Claim-bus bit of each master's write |
| ctl_peer_on | input | 2 | Hand-to-other bit of each master's write |
| ctl_init | input | 2 | Recovery request bit of each master's write |
| msk_we | input | 2 | Mask write strobe, one per master |
| msk_val | input | 6 | Mask values, 3 bits per master |
| stat_rd | input | 2 | Status read-and-clear strobe, one per master |
| up_stop | input | 2 | STOP detected on each master's upstream bus |
| dn_idle | input | 1 | Downstream bus idle (no open START) |
| rec_done | input | 1 | Recovery sequencer finished |
| conn | output | 2 | Connect enable, one-hot or zero |
| rec_start | output | 1 | Recovery run request, held until done |
| int_n | output | 2 | Active-low interrupt per master |
| stat_o | output | 6 | Status flags, 3 bits per master |

## Verification
The case that is hardest to reach from the ports is two requests that compete for the FSM: both ready in the same cycle, or a second STOP arriving while recovery holds the FSM. In both cases the later request must stay latched and be served in a later cycle.

The bench reaches this by posting writes from both masters in one cycle and then presenting their STOPs together, then staggered, then during an open recovery window. It checks the connect lines cycle by cycle afterwards.

A full sweep over current owner, writer, write code, recovery bit and idle level covers the decode and flag rules. A read strobe placed on the same edge as an eviction tests which of the two wins.

// File: rtl/dmba_pkg.sv
package dmba_pkg;
    localparam int NMST    = 2;
    localparam int NFLG    = 3;
    localparam int FL_LOST = 0;
    localparam int FL_INIT = 1;
    localparam int FL_BUSY = 2;

    typedef enum logic {
        ARB_HOLD    = 1'b0,
        ARB_RECOVER = 1'b1
    } arb_state_e;
endpackage

// File: rtl/dmba_req_slot.sv
module dmba_req_slot
    import dmba_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic            self_on,
    input  logic            peer_on,
    input  logic            init_req,
    input  logic            stop,
    input  logic            take,
    output logic            go,
    output logic [NMST-1:0] tgt,
    output logic            init_o
);
    localparam int PEER = (IDX == 0) ? 1 : 0;

    logic            pend_q;
    logic            armed_q;
    logic            init_q;
    logic [NMST-1:0] tgt_q;
    logic [NMST-1:0] wr_tgt;
    logic            wr_ok;

    // decode of the write code into a one-hot target (zero = no owner)
    always_comb begin
        wr_tgt = '0;
        if (self_on && !peer_on) begin
            wr_tgt[IDX] = 1'b1;
        end else if (!self_on && peer_on) begin
            wr_tgt[PEER] = 1'b1;
        end
        wr_ok = we && !(self_on && peer_on);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            armed_q <= 1'b0;
            init_q  <= 1'b0;
            tgt_q   <= '0;
        end else begin
            if (take) begin
                pend_q  <= 1'b0;
                armed_q <= 1'b0;
            end else if (pend_q && stop) begin
                armed_q <= 1'b1;
            end
            if (wr_ok) begin
                pend_q  <= 1'b1;
                armed_q <= 1'b0;
                tgt_q   <= wr_tgt;
                init_q  <= init_req;
            end
        end
    end

    assign go     = pend_q && (armed_q || stop);
    assign tgt    = tgt_q;
    assign init_o = init_q;
endmodule

// File: rtl/dmba_flags.sv
module dmba_flags
    import dmba_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_lost,
    input  logic            set_init,
    input  logic            set_busy,
    input  logic            rd,
    input  logic            msk_we,
    input  logic [NFLG-1:0] msk_val,
    output logic [NFLG-1:0] stat,
    output logic            irq_n
);
    logic [NFLG-1:0] stat_q;
    logic [NFLG-1:0] mask_q;
    logic [NFLG-1:0] set_v;

    always_comb begin
        set_v          = '0;
        set_v[FL_LOST] = set_lost;
        set_v[FL_INIT] = set_init;
        set_v[FL_BUSY] = set_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= (rd ? '0 : stat_q) | set_v;
            if (msk_we) begin
                mask_q <= msk_val;
            end
        end
    end

    assign stat  = stat_q;
    assign irq_n = ~|(stat_q & ~mask_q);
endmodule

// File: rtl/dmbus_arbiter.sv
module dmbus_arbiter
    import dmba_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NMST-1:0]      ctl_we,
    input  logic [NMST-1:0]      ctl_self_on,
    input  logic [NMST-1:0]      ctl_peer_on,
    input  logic [NMST-1:0]      ctl_init,
    input  logic [NMST-1:0]      msk_we,
    input  logic [NMST*NFLG-1:0] msk_val,
    input  logic [NMST-1:0]      stat_rd,
    input  logic [NMST-1:0]      up_stop,
    input  logic                 dn_idle,
    input  logic                 rec_done,
    output logic [NMST-1:0]      conn,
    output logic                 rec_start,
    output logic [NMST-1:0]      int_n,
    output logic [NMST*NFLG-1:0] stat_o
);
    arb_state_e      state_q, nxt_state;
    logic [NMST-1:0] owner_q, nxt_owner;
    logic [NMST-1:0] slot_go;
    logic [NMST-1:0] slot_init;
    logic [NMST-1:0] slot_tgt [NMST];
    logic [NMST-1:0] take;
    logic [NMST-1:0] set_lost, set_init, set_busy;
    logic [NMST-1:0] cand_tgt;
    logic            cand_init;
    logic            fire;

    for (genvar g = 0; g < NMST; g++) begin : g_mst
        dmba_req_slot #(.IDX(g)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (ctl_we[g]),
            .self_on  (ctl_self_on[g]),
            .peer_on  (ctl_peer_on[g]),
            .init_req (ctl_init[g]),
            .stop     (up_stop[g]),
            .take     (take[g]),
            .go       (slot_go[g]),
            .tgt      (slot_tgt[g]),
            .init_o   (slot_init[g])
        );

        dmba_flags u_flags (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_lost (set_lost[g]),
            .set_init (set_init[g]),
            .set_busy (set_busy[g]),
            .rd       (stat_rd[g]),
            .msk_we   (msk_we[g]),
            .msk_val  (msk_val[g*NFLG +: NFLG]),
            .stat     (stat_o[g*NFLG +: NFLG]),
            .irq_n    (int_n[g])
        );
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_HOLD;
            owner_q <= '0;
        end else begin
            state_q <= nxt_state;
            owner_q <= nxt_owner;
        end
    end

    // transitions and flag events; lowest index wins a tie
    always_comb begin
        nxt_state = state_q;
        nxt_owner = owner_q;
        take      = '0;
        set_lost  = '0;
        set_init  = '0;
        set_busy  = '0;
        cand_tgt  = '0;
        cand_init = 1'b0;
        fire      = 1'b0;
        unique case (state_q)
            ARB_HOLD: begin
                for (int i = NMST - 1; i >= 0; i--) begin
                    if (slot_go[i]) begin
                        take      = '0;
                        take[i]   = 1'b1;
                        cand_tgt  = slot_tgt[i];
                        cand_init = slot_init[i];
                        fire      = 1'b1;
                    end
                end
                if (fire && (cand_tgt != owner_q)) begin
                    set_lost  = owner_q;
                    nxt_owner = cand_tgt;
                    if (cand_tgt != '0) begin
                        if (cand_init) begin
                            nxt_state = ARB_RECOVER;
                        end else if (!dn_idle) begin
                            set_busy = cand_tgt;
                        end
                    end
                end
            end
            ARB_RECOVER: begin
                if (rec_done) begin
                    nxt_state = ARB_HOLD;
                    set_init  = owner_q;
                end
            end
            default: ;
        endcase
    end

    // outputs
    always_comb begin
        conn      = (state_q == ARB_HOLD) ? owner_q : '0;
        rec_start = (state_q == ARB_RECOVER);
    end
endmodule

// File: rtl/dmbus_arbiter_chk.sv
module dmbus_arbiter_chk
    import dmba_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [NMST-1:0]      conn,
    input logic                 rec_start,
    input logic                 rec_done,
    input logic [NMST*NFLG-1:0] stat_o
);
    a_r11_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(conn));

    a_r6_isolated_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        rec_start |-> (conn == '0));

    a_r6_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_start && !rec_done) |=> rec_start);

    a_r6_connect_after_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rec_start) |-> (conn != '0));

    for (genvar g = 0; g < NMST; g++) begin : g_lost
        a_r5_lost_on_evict: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(conn[g]) |-> stat_o[g*NFLG + FL_LOST]);
    end
endmodule

bind dmbus_arbiter dmbus_arbiter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conn      (conn),
    .rec_start (rec_start),
    .rec_done  (rec_done),
    .stat_o    (stat_o)
);

// File: tb/dmbus_arbiter_bench.sv
`timescale 1ns/1ps
module dmbus_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] ctl_we, ctl_self_on, ctl_peer_on, ctl_init;
    logic [1:0] msk_we, stat_rd, up_stop;
    logic [5:0] msk_val;
    logic       dn_idle, rec_done;
    logic [1:0] conn, int_n;
    logic       rec_start;
    logic [5:0] stat_o;

    int n_tot = 0;
    int n_bad = 0;

    logic [1:0] ownv, tgt;
    logic [5:0] exp_stat;
    bit         ign, act, recov;

    always #2.5 clk = ~clk;

    dmbus_arbiter u_dmbus_arbiter (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_self_on(ctl_self_on),
        .ctl_peer_on(ctl_peer_on), .ctl_init(ctl_init), .msk_we(msk_we),
        .msk_val(msk_val), .stat_rd(stat_rd), .up_stop(up_stop),
        .dn_idle(dn_idle), .rec_done(rec_done), .conn(conn),
        .rec_start(rec_start), .int_n(int_n), .stat_o(stat_o)
    );

    task automatic chk(input string rq, input string what, input int actv, input int expv);
        n_tot++;
        if (actv != expv) begin
            n_bad++;
            $display("FAIL %s %s act=%0d exp=%0d", rq, what, actv, expv);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ctl_we = '0; ctl_self_on = '0; ctl_peer_on = '0; ctl_init = '0;
        msk_we = '0; msk_val = '0; stat_rd = '0; up_stop = '0;
        dn_idle = 1'b1; rec_done = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input int m, input bit s, input bit p, input bit i);
        ctl_we[m] = 1'b1; ctl_self_on[m] = s; ctl_peer_on[m] = p; ctl_init[m] = i;
        @(negedge clk);
        ctl_we = '0; ctl_self_on = '0; ctl_peer_on = '0; ctl_init = '0;
    endtask

    task automatic stop(input int m);
        up_stop[m] = 1'b1;
        @(negedge clk);
        up_stop = '0;
    endtask

    task automatic rdone();
        rec_done = 1'b1;
        @(negedge clk);
        rec_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tot++; n_bad++;
        $display("FAIL R3 watchdog expired act=0 exp=1");
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1", "conn", conn, 0);
        chk("R1", "rec_start", rec_start, 0);
        chk("R1", "stat_o", stat_o, 0);
        chk("R1", "int_n", int_n, 3);

        // sweep: owner x writer x code x recovery x idle
        for (int o = 0; o < 3; o++) begin
            for (int w = 0; w < 2; w++) begin
                for (int code = 0; code < 4; code++) begin
                    for (int ini = 0; ini < 2; ini++) begin
                        for (int idl = 0; idl < 2; idl++) begin
                            do_reset();
                            ownv = (o == 0) ? 2'b00 : 2'(1 << (o - 1));
                            if (o != 0) begin
                                wr(o - 1, 1'b1, 1'b0, 1'b0);
                                stop(o - 1);
                            end
                            chk("R3", "setup conn", conn, ownv);
                            wr(w, code[0], code[1], ini[0]);
                            dn_idle = idl[0];
                            stop(1 - w);
                            chk("R3", "foreign stop conn", conn, ownv);
                            ign = (code == 3);
                            tgt = (code == 1) ? 2'(1 << w) :
                                  (code == 2) ? 2'(1 << (1 - w)) : 2'b00;
                            act = !ign && (tgt != ownv);
                            recov = act && (tgt != 0) && (ini == 1);
                            exp_stat = '0;
                            stop(w);
                            if (act) begin
                                if (ownv[0]) exp_stat[0] = 1'b1;
                                if (ownv[1]) exp_stat[3] = 1'b1;
                                if (recov) begin
                                    chk("R6", "conn in recovery", conn, 0);
                                    chk("R6", "rec_start", rec_start, 1);
                                end else begin
                                    chk("R2", "conn after switch", conn, tgt);
                                    chk("R6", "no rec_start", rec_start, 0);
                                    if (tgt[0] && idl == 0) exp_stat[2] = 1'b1;
                                    if (tgt[1] && idl == 0) exp_stat[5] = 1'b1;
                                end
                            end else begin
                                chk(ign ? "R2" : "R4", "conn unchanged", conn, ownv);
                                chk("R4", "no rec_start", rec_start, 0);
                            end
                            if (recov) begin
                                rdone();
                                chk("R6", "conn after recovery", conn, tgt);
                                chk("R6", "rec_start low", rec_start, 0);
                                if (tgt[0]) exp_stat[1] = 1'b1;
                                if (tgt[1]) exp_stat[4] = 1'b1;
                            end
                            chk("R5", "stat_o flags (R7)", stat_o, exp_stat);
                            chk("R8", "int_n", int_n, {~|exp_stat[5:3], ~|exp_stat[2:0]});
                            dn_idle = 1'b1;
                        end
                    end
                end
            end
        end

        // R10 both ready in the same cycle
        do_reset();
        ctl_we = 2'b11; ctl_self_on = 2'b11;
        @(negedge clk);
        ctl_we = '0; ctl_self_on = '0;
        up_stop = 2'b11;
        @(negedge clk);
        up_stop = '0;
        chk("R10", "tie first owner", conn, 1);
        @(negedge clk);
        chk("R10", "tie second owner", conn, 2);
        chk("R5", "tie lost m0", stat_o[0], 1);

        // R10 earlier stop wins
        do_reset();
        ctl_we = 2'b11; ctl_self_on = 2'b11;
        @(negedge clk);
        ctl_we = '0; ctl_self_on = '0;
        stop(1);
        chk("R10", "first stop served", conn, 2);
        stop(0);
        chk("R10", "later stop served", conn, 1);
        chk("R5", "lost m1", stat_o[3], 1);

        // R8 masks, R9 read clear
        do_reset();
        wr(0, 1'b1, 1'b0, 1'b0); stop(0);
        wr(1, 1'b1, 1'b0, 1'b0); stop(1);
        chk("R8", "int_n m0 low", int_n[0], 0);
        msk_we = 2'b01; msk_val = 6'b000_001;
        @(negedge clk);
        msk_we = '0;
        chk("R8", "masked int_n m0", int_n[0], 1);
        chk("R8", "flag kept under mask", stat_o[0], 1);
        msk_we = 2'b01; msk_val = 6'b000_010;
        @(negedge clk);
        msk_we = '0;
        chk("R8", "other mask bit", int_n[0], 0);
        stat_rd = 2'b10;
        @(negedge clk);
        stat_rd = '0;
        chk("R9", "read m1 keeps m0", stat_o[2:0], 1);
        stat_rd = 2'b01;
        @(negedge clk);
        stat_rd = '0;
        chk("R9", "read m0 clears", stat_o[2:0], 0);
        chk("R8", "int_n m0 released", int_n[0], 1);
        wr(0, 1'b1, 1'b0, 1'b0);
        stat_rd = 2'b10; up_stop = 2'b01;
        @(negedge clk);
        stat_rd = '0; up_stop = '0;
        chk("R9", "set wins over read", stat_o[5:3], 1);
        chk("R3", "conn back to m0", conn, 1);

        // R3 stop before write does nothing
        do_reset();
        stop(0);
        wr(0, 1'b1, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R3", "early stop ignored", conn, 0);
        stop(0);
        chk("R3", "stop after write", conn, 1);

        // R10 stop held through recovery
        do_reset();
        wr(0, 1'b1, 1'b0, 1'b1);
        stop(0);
        chk("R6", "recovery open", rec_start, 1);
        wr(1, 1'b1, 1'b0, 1'b0);
        stop(1);
        chk("R10", "no switch in recovery", conn, 0);
        chk("R6", "still recovering", rec_start, 1);
        rdone();
        chk("R6", "m0 connected", conn, 1);
        chk("R6", "init flag m0", stat_o[1], 1);
        @(negedge clk);
        chk("R10", "held stop served", conn, 2);
        chk("R5", "m0 lost", stat_o[0], 1);

        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end
endmodule